// File: doc/BRIEF.md
# Programmer Control Register and Programming-Rail Selector

This block holds the write-only control state of an on-board device programmer that sits on an 8-bit CPU bus. A bus write is decoded for exactly two I/O addresses. One address loads a control register whose eight bits drive the target device's strobes and address lines, the status lamps, the memory-map swap and the programming enables. The other address loads an upper-address latch. The low six bits of that latch drive target address lines, and its top two bits hold a voltage code.

From these two registers the block derives registered, mutually exclusive enables for the 5 V, 12 V and 21 V sources on the programming rail. It also drives a separate output that pulls the rail to ground. The control register clears on reset, but the latch does not. A reset therefore leaves the voltage code in place while it forces the rail back to 5 V, because the program-enable bit clears. A pull-to-ground request overrides every source, so the rail never has two drivers.

Top module: `eprom_prog_ctrl`

## Requirements
- R1: A bus cycle with bus_sel=1, bus_rw=0 and bus_addr=01FEh loads bus_wdata into the control register on that clock edge. The outputs follow its bits: bit0 map_swap, bit1 vpp_pull_req, bit2 tgt_oe, bit3 spare_led, bit4 tgt_a14, bit5 pgm_en, bit6 tgt_reset, bit7 tgt_a4.
- R2: A bus cycle with bus_sel=1, bus_rw=0 and bus_addr=01FBh loads bus_wdata into the upper-address latch on that clock edge. Bits 5..0 appear on tgt_addr_hi. Bit 6 (code low, Z6) and bit 7 (code high, Z7) form the voltage code.
- R3: Both registers keep their value on a read cycle (bus_rw=1), on a write to any other address, and whenever bus_sel=0.
- R4: Reset clears the control register to 00h. The upper-address latch keeps its value across reset.
- R5: When control bit 1 is 0 and control bit 5 is 0, only the 5 V enable is asserted, whatever the code.
- R6: When control bit 1 is 0 and control bit 5 is 1, the code selects the source. Z6=0 and Z7=1 select 12 V. Z6=1 and Z7=0 select 21 V. Z6=0 and Z7=0 select 5 V.
- R7: When control bit 1 is 0, control bit 5 is 1, Z6=1 and Z7=1, no source enable is asserted and code_err is 1. In every other state code_err is 0.
- R8: When control bit 1 is 1, all three source enables are deasserted, vpp_gnd is 1 and code_err is 0.
- R9: The source enables are active low, which is the default, and at most one is asserted. Together with vpp_gnd and code_err they change one clock edge after the register write that affects them. During and after reset, only the 5 V enable is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Bus I/O cycle valid |
| bus_rw | input | 1 | 1 = read, 0 = write |
| bus_addr | input | 16 | Bus address |
| bus_wdata | input | 8 | Bus write data |
| map_swap | output | 1 | Memory map swap (0 = ROM at top) |
| vpp_pull_req | output | 1 | Rail pull-low request and DATA lamp |
| tgt_oe | output | 1 | Target output-enable line |
| spare_led | output | 1 | Spare lamp |
| tgt_a14 | output | 1 | Target address line 14 |
| pgm_en | output | 1 | Programming enable and PGM lamp |
| tgt_reset | output | 1 | Target reset line |
| tgt_a4 | output | 1 | Target A4 input |
| tgt_addr_hi | output | 6 | Target address lines 8..13 |
| vpp5_sel | output | 1 | 5 V source enable, active low |
| vpp12_sel | output | 1 | 12 V source enable, active low |
| vpp21_sel | output | 1 | 21 V source enable, active low |
| vpp_gnd | output | 1 | Rail pull-to-ground enable |
| code_err | output | 1 | Illegal voltage code while programming |

## Verification
On every cycle, the assertions check four properties: a decoded write lands in its register one edge later, registers that are not written stay stable, at most one rail driver is active, and the pull-low, idle and illegal-code cases produce their rail state on the following edge. Some behaviour is visible only in the bench scenarios. These include the latch keeping its code across a reset while the control register clears, the one-cycle lag of the rail outputs behind a write, reads and foreign-address writes leaving both registers untouched, and a sweep of every code under every combination of the enable and pull bits.

// File: rtl/eprom_prog_pkg.sv
package eprom_prog_pkg;
   localparam int unsigned REG_W     = 8;
   localparam int unsigned HI_ADDR_W = REG_W - 2;
   // control register bit positions
   localparam int unsigned B_SWAP  = 0;
   localparam int unsigned B_PULL  = 1;
   localparam int unsigned B_OE    = 2;
   localparam int unsigned B_SPARE = 3;
   localparam int unsigned B_A14   = 4;
   localparam int unsigned B_PGM   = 5;
   localparam int unsigned B_TRST  = 6;
   localparam int unsigned B_A4    = 7;
   // code field: {Z7,Z6}
   localparam logic [1:0] CODE_5V   = 2'b00;
   localparam logic [1:0] CODE_21V  = 2'b01;
   localparam logic [1:0] CODE_12V  = 2'b10;
   localparam logic [1:0] CODE_BAD  = 2'b11;

   typedef struct packed {
      logic gnd;
      logic v21;
      logic v12;
      logic v5;
   } rail_t;
endpackage

// File: rtl/prog_wr_decode.sv
module prog_wr_decode #(
   parameter int unsigned ADDR_W   = 16,
   parameter int unsigned CTL_ADDR = 'h1FE,
   parameter int unsigned HI_ADDR  = 'h1FB
) (
   input  logic              bus_sel,
   input  logic              bus_rw,
   input  logic [ADDR_W-1:0] bus_addr,
   output logic              wr_ctl,
   output logic              wr_hi
);
   localparam logic [ADDR_W-1:0] CTL_A = ADDR_W'(CTL_ADDR);
   localparam logic [ADDR_W-1:0] HI_A  = ADDR_W'(HI_ADDR);

   logic wr_cycle;

   always_comb begin
      wr_cycle = bus_sel && !bus_rw;
      wr_ctl   = wr_cycle && (bus_addr == CTL_A);
      wr_hi    = wr_cycle && (bus_addr == HI_A);
   end

   always_comb begin
      a_r3_single_target: assert (!(wr_ctl && wr_hi));
   end
endmodule

// File: rtl/prog_regs.sv
module prog_regs
   import eprom_prog_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_ctl,
   input  logic             wr_hi,
   input  logic [REG_W-1:0] wdata,
   output logic [REG_W-1:0] ctl_q,
   output logic [REG_W-1:0] hi_q
);
   logic [REG_W-1:0] ctl_r;
   logic [REG_W-1:0] hi_r = '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ctl_r <= '0;
      else if (wr_ctl) ctl_r <= wdata;
   end

   // no reset: code must survive a board reset
   always_ff @(posedge clk) begin
      if (wr_hi) hi_r <= wdata;
   end

   assign ctl_q = ctl_r;
   assign hi_q  = hi_r;

   a_r1_ctl_load: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctl |=> ctl_q == $past(wdata));
   a_r2_hi_load: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hi |=> hi_q == $past(wdata));
   a_r3_ctl_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_ctl |=> $stable(ctl_q));
   a_r3_hi_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_hi |=> $stable(hi_q));
endmodule

// File: rtl/vpp_select.sv
module vpp_select
   import eprom_prog_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pull_req,
   input  logic       pgm,
   input  logic [1:0] code,
   output rail_t      rail,
   output logic       err
);
   rail_t rail_d;
   logic  err_d;

   always_comb begin
      rail_d = '0;
      err_d  = 1'b0;
      if (pull_req) begin
         rail_d.gnd = 1'b1;
      end else if (!pgm) begin
         rail_d.v5 = 1'b1;
      end else begin
         unique case (code)
            CODE_5V:  rail_d.v5  = 1'b1;
            CODE_12V: rail_d.v12 = 1'b1;
            CODE_21V: rail_d.v21 = 1'b1;
            default:  err_d      = 1'b1;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rail <= '{gnd: 1'b0, v21: 1'b0, v12: 1'b0, v5: 1'b1};
         err  <= 1'b0;
      end else begin
         rail <= rail_d;
         err  <= err_d;
      end
   end

   a_r9_one_driver: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rail.gnd, rail.v21, rail.v12, rail.v5}));
   a_r8_pull_wins: assert property (@(posedge clk) disable iff (!rst_n)
      pull_req |=> rail.gnd && !rail.v5 && !rail.v12 && !rail.v21 && !err);
   a_r5_idle_5v: assert property (@(posedge clk) disable iff (!rst_n)
      (!pull_req && !pgm) |=> rail.v5 && !err);
   a_r7_bad_code: assert property (@(posedge clk) disable iff (!rst_n)
      (!pull_req && pgm && code == CODE_BAD) |=>
         err && !rail.v5 && !rail.v12 && !rail.v21 && !rail.gnd);
   a_r7_err_only_bad: assert property (@(posedge clk) disable iff (!rst_n)
      !(pgm && !pull_req && code == CODE_BAD) |=> !err);
endmodule

// File: rtl/eprom_prog_ctrl.sv
module eprom_prog_ctrl
   import eprom_prog_pkg::*;
#(
   parameter int unsigned ADDR_W         = 16,
   parameter int unsigned CTL_ADDR       = 'h1FE,
   parameter int unsigned HI_ADDR        = 'h1FB,
   parameter bit          SEL_ACTIVE_LOW = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_sel,
   input  logic                 bus_rw,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [REG_W-1:0]     bus_wdata,
   output logic                 map_swap,
   output logic                 vpp_pull_req,
   output logic                 tgt_oe,
   output logic                 spare_led,
   output logic                 tgt_a14,
   output logic                 pgm_en,
   output logic                 tgt_reset,
   output logic                 tgt_a4,
   output logic [HI_ADDR_W-1:0] tgt_addr_hi,
   output logic                 vpp5_sel,
   output logic                 vpp12_sel,
   output logic                 vpp21_sel,
   output logic                 vpp_gnd,
   output logic                 code_err
);
   localparam longint unsigned ADDR_SPAN = 64'd1 << ADDR_W;

   initial begin
      p_addr_w: assert (ADDR_W >= 9 && ADDR_W <= 32);
      p_ctl_fits: assert (64'(CTL_ADDR) < ADDR_SPAN);
      p_hi_fits: assert (64'(HI_ADDR) < ADDR_SPAN);
      p_distinct: assert (CTL_ADDR != HI_ADDR);
   end

   logic             wr_ctl, wr_hi;
   logic [REG_W-1:0] ctl_q, hi_q;
   rail_t            rail;
   logic             err;

   prog_wr_decode #(
      .ADDR_W   (ADDR_W),
      .CTL_ADDR (CTL_ADDR),
      .HI_ADDR  (HI_ADDR)
   ) u_dec (
      .bus_sel  (bus_sel),
      .bus_rw   (bus_rw),
      .bus_addr (bus_addr),
      .wr_ctl   (wr_ctl),
      .wr_hi    (wr_hi)
   );

   prog_regs u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_ctl (wr_ctl),
      .wr_hi  (wr_hi),
      .wdata  (bus_wdata),
      .ctl_q  (ctl_q),
      .hi_q   (hi_q)
   );

   vpp_select u_sel (
      .clk      (clk),
      .rst_n    (rst_n),
      .pull_req (ctl_q[B_PULL]),
      .pgm      (ctl_q[B_PGM]),
      .code     (hi_q[REG_W-1 -: 2]),
      .rail     (rail),
      .err      (err)
   );

   assign map_swap     = ctl_q[B_SWAP];
   assign vpp_pull_req = ctl_q[B_PULL];
   assign tgt_oe       = ctl_q[B_OE];
   assign spare_led    = ctl_q[B_SPARE];
   assign tgt_a14      = ctl_q[B_A14];
   assign pgm_en       = ctl_q[B_PGM];
   assign tgt_reset    = ctl_q[B_TRST];
   assign tgt_a4       = ctl_q[B_A4];
   assign tgt_addr_hi  = hi_q[HI_ADDR_W-1:0];
   assign vpp_gnd      = rail.gnd;
   assign code_err     = err;

   generate
      if (SEL_ACTIVE_LOW) begin : g_sel_low
         assign vpp5_sel  = ~rail.v5;
         assign vpp12_sel = ~rail.v12;
         assign vpp21_sel = ~rail.v21;
      end else begin : g_sel_high
         assign vpp5_sel  = rail.v5;
         assign vpp12_sel = rail.v12;
         assign vpp21_sel = rail.v21;
      end
   endgenerate

   a_r4_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> ctl_q == '0);
   a_r8_gnd_excl: assert property (@(posedge clk) disable iff (!rst_n)
      vpp_gnd |-> !code_err && !rail.v5 && !rail.v12 && !rail.v21);
endmodule

// File: tb/eprom_prog_ctrl_bench.sv
module eprom_prog_ctrl_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_rw = 1'b1;
   logic [15:0] bus_addr = '0;
   logic [7:0]  bus_wdata = '0;
   logic map_swap, vpp_pull_req, tgt_oe, spare_led, tgt_a14, pgm_en, tgt_reset, tgt_a4;
   logic [5:0] tgt_addr_hi;
   logic vpp5_sel, vpp12_sel, vpp21_sel, vpp_gnd, code_err;

   always #2 clk = ~clk;

   eprom_prog_ctrl u_eprom_prog_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_rw(bus_rw),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .map_swap(map_swap), .vpp_pull_req(vpp_pull_req), .tgt_oe(tgt_oe),
      .spare_led(spare_led), .tgt_a14(tgt_a14), .pgm_en(pgm_en),
      .tgt_reset(tgt_reset), .tgt_a4(tgt_a4), .tgt_addr_hi(tgt_addr_hi),
      .vpp5_sel(vpp5_sel), .vpp12_sel(vpp12_sel), .vpp21_sel(vpp21_sel),
      .vpp_gnd(vpp_gnd), .code_err(code_err)
   );

   int n_vec = 0;
   int n_bad = 0;
   bit started = 1'b0;

   // reference model state
   int m_ctl = 0;
   int m_hi  = 0;
   int m_rail = 1;   // 1=5V 2=12V 3=21V 4=gnd 0=none
   int m_err = 0;

   task automatic chk(input string tag, input int act, input int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic int rail_now();
      if (!vpp_gnd && !vpp5_sel && vpp12_sel && vpp21_sel) return 1;
      if (!vpp_gnd && vpp5_sel && !vpp12_sel && vpp21_sel) return 2;
      if (!vpp_gnd && vpp5_sel && vpp12_sel && !vpp21_sel) return 3;
      if (vpp_gnd && vpp5_sel && vpp12_sel && vpp21_sel) return 4;
      if (!vpp_gnd && vpp5_sel && vpp12_sel && vpp21_sel) return 0;
      return 9;
   endfunction

   function automatic int ctl_now();
      return {24'd0, tgt_a4, tgt_reset, pgm_en, tgt_a14, spare_led, tgt_oe, vpp_pull_req, map_swap};
   endfunction

   always @(posedge clk) begin
      started = 1'b1;
      if (!rst_n) begin
         m_ctl = 0; m_rail = 1; m_err = 0;
      end else begin
         int z6, z7;
         z6 = (m_hi >> 6) & 1;
         z7 = (m_hi >> 7) & 1;
         m_err = 0;
         if ((m_ctl >> 1) & 1) m_rail = 4;
         else if (((m_ctl >> 5) & 1) == 0) m_rail = 1;
         else if (z6 == 0 && z7 == 0) m_rail = 1;
         else if (z6 == 0 && z7 == 1) m_rail = 2;
         else if (z6 == 1 && z7 == 0) m_rail = 3;
         else begin m_rail = 0; m_err = 1; end
         if (bus_sel && !bus_rw && bus_addr == 16'h01FE) m_ctl = bus_wdata;
      end
      if (bus_sel && !bus_rw && bus_addr == 16'h01FB) m_hi = bus_wdata;
   end

   // continuous comparison against the model
   always @(negedge clk) begin
      if (started) begin
         string rtag;
         if ((m_ctl >> 1) & 1) rtag = "R8";
         else if (((m_ctl >> 5) & 1) == 0) rtag = "R5";
         else if (m_err != 0) rtag = "R7";
         else rtag = "R6";
         chk("R1 control outputs", ctl_now(), m_ctl);
         chk("R2 upper address", int'(tgt_addr_hi), m_hi & 'h3F);
         chk({rtag, " rail state"}, rail_now(), m_rail);
         chk({rtag, " code_err"}, int'(code_err), m_err);
      end
   end

   task automatic bus_cycle(input logic rw, input logic [15:0] a, input logic [7:0] d, input logic sel);
      @(negedge clk);
      bus_sel = sel; bus_rw = rw; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_rw = 1'b1;
   endtask

   task automatic wr(input logic [15:0] a, input logic [7:0] d);
      bus_cycle(1'b0, a, d, 1'b1);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      #(4 * 100000);
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      idle(3);
      // R4, R9 reset state
      chk("R4 control clear in reset", ctl_now(), 0);
      chk("R9 5V in reset", rail_now(), 1);
      @(negedge clk); rst_n = 1'b1;
      idle(2);

      // R2 latch load, R6 5V code
      wr(16'h01FB, 8'h2A);
      chk("R2 addr hi 2A", int'(tgt_addr_hi), 'h2A);
      wr(16'h01FE, 8'h20);
      idle(1);
      chk("R6 code 00 gives 5V", rail_now(), 1);
      // R6 12V
      wr(16'h01FB, 8'h80);
      idle(1);
      chk("R6 Z7=1 gives 12V", rail_now(), 2);
      // R9 latency: 21V appears one edge after write
      wr(16'h01FB, 8'h40);
      chk("R9 rail lags write", rail_now(), 2);
      idle(1);
      chk("R6 Z6=1 gives 21V", rail_now(), 3);
      // R7 bad code
      wr(16'h01FB, 8'hC0);
      idle(1);
      chk("R7 bad code no source", rail_now(), 0);
      chk("R7 bad code err", int'(code_err), 1);
      // R8 pull-low overrides
      wr(16'h01FE, 8'h22);
      idle(1);
      chk("R8 pull-low gnd", rail_now(), 4);
      chk("R8 err cleared", int'(code_err), 0);
      // R3 ignored cycles
      bus_cycle(1'b1, 16'h01FE, 8'hFF, 1'b1);
      bus_cycle(1'b1, 16'h01FB, 8'h3F, 1'b1);
      wr(16'h01FD, 8'hFF);
      wr(16'h00FE, 8'hFF);
      bus_cycle(1'b0, 16'h01FE, 8'hFF, 1'b0);
      idle(1);
      chk("R3 control unchanged", ctl_now(), 'h22);
      chk("R3 latch unchanged", int'(tgt_addr_hi), 0);
      // R1 bit mapping
      wr(16'h01FE, 8'h5D);
      chk("R1 pattern 5D", ctl_now(), 'h5D);
      wr(16'h01FE, 8'hA2);
      chk("R1 pattern A2", ctl_now(), 'hA2);
      // R4 reset keeps latch
      wr(16'h01FB, 8'hC5);
      wr(16'h01FE, 8'h20);
      idle(1);
      @(negedge clk); rst_n = 1'b0;
      idle(2);
      chk("R4 control cleared", ctl_now(), 0);
      chk("R4 latch kept", int'(tgt_addr_hi), 'h05);
      @(negedge clk); rst_n = 1'b1;
      idle(1);
      chk("R5 after reset 5V", rail_now(), 1);
      wr(16'h01FE, 8'h20);
      idle(1);
      chk("R4 code survived reset", int'(code_err), 1);
      // sweep of all codes, pgm, pull
      for (int c = 0; c < 4; c++) begin
         for (int p = 0; p < 4; p++) begin
            wr(16'h01FB, 8'(c << 6) | 8'h11);
            wr(16'h01FE, ((p & 1) != 0 ? 8'h20 : 8'h00) | ((p & 2) != 0 ? 8'h02 : 8'h00));
            idle(2);
         end
      end
      idle(2);
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule